// File: doc/BRIEF.md
# Microsecond Event Timer

This block is a single down-counting event timer that advances on an external one-microsecond tick enable. Software programs it through a trigger register. That register carries an enable bit, a periodic-mode bit and a count field, all written in one access. The timer raises a level-high interrupt when the count runs out. A separate status register reports the remaining count and the pending flag, and a write to it acknowledges the interrupt.

The count field holds the number of ticks minus one, so a programmed value of N produces an event after N+1 ticks. In one-shot mode the timer disarms itself when it fires. In periodic mode it reloads the programmed value on the expiring tick and keeps running without losing a tick. For example, periodic mode with a value of 9999 yields a 100 Hz interrupt from a 1 MHz tick.

Top module: `us_event_timer`

## Requirements
- R1: After reset, irq is low and reads at offset 0 (trigger) and offset 4 (status) both return zero.
- R2: Trigger register layout: bit 31 is the enable bit, bit 30 is the periodic bit and bits 28:0 are the count. A read returns the written enable, periodic and count fields. Bit 29 and any unused bits read as zero.
- R3: After a value N is written with enable set, the event fires on the (N+1)th tick. The count moves only on a tick while the timer is enabled, and a write with enable clear loads the count without starting it.
- R4: In one-shot mode (bit 30 clear), the enable bit clears on expiry and the count stays at zero. Later ticks raise no further event.
- R5: In periodic mode (bit 30 set), the expiring tick reloads the programmed count and the enable stays set. Events repeat every N+1 ticks.
- R6: Writing zero to the trigger register stops the timer. After that, ticks change neither the count nor irq.
- R7: A trigger write while the timer is running restarts the countdown from the new value.
- R8: A status read returns the remaining count in bits 28:0 and the pending flag in bit 30.
- R9: Writing a 1 to bit 30 of the status register clears the pending flag. A status write with bit 30 clear has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R10: irq is a level that follows the pending flag. It stays high until it is acknowledged.
- R11: The largest count, 0x1FFFFFFF, is accepted and counts down like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1us | input | 1 | One-cycle tick enable, one per microsecond |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset: 0 selects trigger, 4 selects status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest situation to reach from the ports is the race between an acknowledge and a new expiry in the same clock cycle. The bench reaches it by programming a short one-shot count, stepping ticks until the count reaches zero, and then driving the expiring tick and the status write on one edge. Reload without a lost tick is checked by sweeping several small periodic counts across repeated periods and counting the ticks between events.

// File: rtl/us_timer_pkg.sv
// Package: shared field positions and register offsets for the event timer.
// Assumes a 32-bit register bus with a byte-addressed offset.
package us_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 29;
    localparam int EN_BIT   = 31;
    localparam int PER_BIT  = 30;
    localparam int ACK_BIT  = 30;
    localparam int OFF_TRIG = 0;
    localparam int OFF_STAT = 4;

    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/tmr_regif.sv
// Module: register decode. It turns a bus write into trigger and acknowledge
// strobes and multiplexes read data. It assumes one write per strobe cycle
// and combinational reads.
module tmr_regif
    import us_timer_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              en,
    input  logic              per,
    input  cnt_t              reload,
    input  cnt_t              cnt,
    input  logic              pend,
    output logic              wr_trig,
    output logic              ack,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFF_TRIG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    // Write strobes: trigger load, and acknowledge only when bit 30 is set.
    always_comb begin
        wr_trig = bus_wr && (bus_addr == A_TRIG);
        ack     = bus_wr && (bus_addr == A_STAT) && bus_wdata[ACK_BIT];
    end

    // Read mux: trigger fields or status (count plus pending flag).
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_TRIG) begin
            bus_rdata[EN_BIT]    = en;
            bus_rdata[PER_BIT]   = per;
            bus_rdata[CNT_W-1:0] = reload;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[ACK_BIT]   = pend;
            bus_rdata[CNT_W-1:0] = cnt;
        end
    end
endmodule

// File: rtl/tmr_core.sv
// Module: countdown state. It holds enable, mode, reload value, live count and
// the pending flag. It assumes tick is a single-cycle enable. A trigger write
// takes priority over a tick in the same cycle, and an expiry takes priority
// over an acknowledge.
module tmr_core
    import us_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_trig,
    input  logic              ack,
    input  logic [DATA_W-1:0] wdata,
    output logic              en,
    output logic              per,
    output cnt_t              reload,
    output cnt_t              cnt,
    output logic              pend
);
    logic fire;
    logic unused_bit29;

    assign unused_bit29 = wdata[CNT_W];

    // Expiry: an enabled tick at zero count that no write overrides.
    always_comb fire = tick && en && (cnt == '0) && !wr_trig;

    // Timer state: load on a write, else count down, reload or disarm on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            per    <= 1'b0;
            reload <= '0;
            cnt    <= '0;
        end else if (wr_trig) begin
            en     <= wdata[EN_BIT];
            per    <= wdata[PER_BIT];
            reload <= wdata[CNT_W-1:0];
            cnt    <= wdata[CNT_W-1:0];
        end else if (tick && en) begin
            if (cnt == '0) begin
                if (per) cnt <= reload;
                else     en  <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Pending flag: set by expiry, cleared by acknowledge, with set winning.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (fire) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end
endmodule

// File: rtl/us_event_timer.sv
// Module: top of the microsecond event timer. It connects register decode to
// the countdown core and drives the level interrupt. It assumes one instance
// per register window, with the tick generated outside.
module us_event_timer
    import us_timer_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic wr_trig, ack, en_q, per_q, pend_q;
    cnt_t reload_q, cnt_q;

    tmr_regif #(.ADDR_W(ADDR_W)) u_regif (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .en(en_q), .per(per_q), .reload(reload_q), .cnt(cnt_q), .pend(pend_q),
        .wr_trig(wr_trig), .ack(ack), .bus_rdata(bus_rdata)
    );

    tmr_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_1us), .wr_trig(wr_trig), .ack(ack),
        .wdata(bus_wdata), .en(en_q), .per(per_q), .reload(reload_q),
        .cnt(cnt_q), .pend(pend_q)
    );

    // Interrupt output: level copy of the pending flag.
    always_comb irq = pend_q;
endmodule

// File: rtl/tmr_checker.sv
// Module: property checker for us_event_timer, attached by bind.
module tmr_checker
    import us_timer_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic wr_trig,
    input logic ack,
    input logic en,
    input logic per,
    input cnt_t reload,
    input cnt_t cnt,
    input logic irq
);
    logic fire;
    always_comb fire = tick && en && (cnt == '0) && !wr_trig;

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !wr_trig && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    a_r4_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !per) |=> (!en && irq && cnt == '0));

    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && per) |=> (en && irq && cnt == $past(reload)));

    a_r6_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_trig) |=> ($stable(cnt) && !$rose(irq)));

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fire) |=> !irq);

    a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
endmodule

bind us_event_timer tmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_1us), .wr_trig(wr_trig), .ack(ack),
    .en(en_q), .per(per_q), .reload(reload_q), .cnt(cnt_q), .irq(irq)
);

// File: tb/sim_us_event_timer.sv
`timescale 1ns/1ps
module sim_us_event_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;

    localparam logic [31:0] ENA = 32'h8000_0000;
    localparam logic [31:0] PER = 32'h4000_0000;
    localparam logic [31:0] ACK = 32'h4000_0000;

    us_event_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1us = 1'b1; @(negedge clk);
            tick_1us = 1'b0; @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(3'd0, v); chk("R1 trig", v, 32'd0);
        rd(3'd4, v); chk("R1 stat", v, 32'd0);
        tk(3);
        rd(3'd4, v); chk("R6 idle after reset", v, 32'd0);

        // R2 readback, bit 29 drops out
        wr(3'd0, 32'hE000_0005);
        rd(3'd0, v); chk("R2 readback", v, 32'hC000_0005);
        wr(3'd0, 32'd0);

        // R3 load without enable does not count
        wr(3'd0, 32'd5);
        tk(3);
        rd(3'd4, v); chk("R3 disabled hold", v, 32'd5);

        // R3/R4/R8 one-shot sweep
        for (int n = 0; n < 6; n++) begin
            wr(3'd0, ENA | n);
            tk(n);
            chk("R3 no early fire", {31'd0, irq}, 32'd0);
            rd(3'd4, v); chk("R8 count zero", v, 32'd0);
            tk(1);
            chk("R3 fire at N+1", {31'd0, irq}, 32'd1);
            rd(3'd4, v); chk("R8 pending flag", v, ACK);
            rd(3'd0, v); chk("R4 enable cleared", v, n);
            tk(4);
            rd(3'd4, v); chk("R4 stays stopped", v, ACK);
            wr(3'd4, 32'h3FFF_FFFF);
            chk("R9 ack without bit30 ignored", {31'd0, irq}, 32'd1);
            wr(3'd4, ACK);
            chk("R9 ack clears", {31'd0, irq}, 32'd0);
            tk(3);
            chk("R4 no second event", {31'd0, irq}, 32'd0);
        end

        // R5 periodic sweep
        for (int n = 0; n < 5; n++) begin
            wr(3'd0, ENA | PER | n);
            for (int p = 0; p < 3; p++) begin
                tk(n);
                chk("R5 no early fire", {31'd0, irq}, 32'd0);
                tk(1);
                chk("R5 periodic fire", {31'd0, irq}, 32'd1);
                rd(3'd4, v); chk("R5 reloaded", v, ACK | n);
                rd(3'd0, v); chk("R5 enable kept", v, ENA | PER | n);
                wr(3'd4, ACK);
                chk("R10 acked", {31'd0, irq}, 32'd0);
            end
            wr(3'd0, 32'd0);
        end

        // R5 100 Hz: 9999 gives 10000 ticks
        wr(3'd0, ENA | PER | 32'd9999);
        tk(9999);
        chk("R5 100Hz early", {31'd0, irq}, 32'd0);
        tk(1);
        chk("R5 100Hz fire", {31'd0, irq}, 32'd1);
        wr(3'd4, ACK);

        // R6 stop by writing zero
        wr(3'd0, ENA | 32'd3);
        tk(2);
        wr(3'd0, 32'd0);
        tk(10);
        chk("R6 stopped irq", {31'd0, irq}, 32'd0);
        rd(3'd4, v); chk("R6 stopped count", v, 32'd0);

        // R7 restart while running
        wr(3'd0, ENA | 32'd10);
        tk(3);
        rd(3'd4, v); chk("R7 mid count", v, 32'd7);
        wr(3'd0, ENA | 32'd2);
        tk(2);
        chk("R7 not yet", {31'd0, irq}, 32'd0);
        tk(1);
        chk("R7 fires from new value", {31'd0, irq}, 32'd1);
        wr(3'd4, ACK);

        // R9 expiry and acknowledge on the same edge: set wins
        wr(3'd0, ENA | 32'd1);
        tk(1);
        tick_1us = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = ACK;
        @(negedge clk);
        tick_1us = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
        chk("R9 set beats clear", {31'd0, irq}, 32'd1);
        wr(3'd4, ACK);

        // R11 maximum count
        wr(3'd0, ENA | 32'h1FFF_FFFF);
        rd(3'd4, v); chk("R11 max loaded", v, 32'h1FFF_FFFF);
        tk(1);
        rd(3'd4, v); chk("R11 max counts", v, 32'h1FFF_FFFE);
        wr(3'd0, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule